// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by reading a two-level page table held in memory. A request carries the virtual address and the kind of access wanted: read, write or execute. The walker forms the first-level entry address from a table base input and the top ten address bits. It then issues one memory read. If that entry is valid, the entry's page number locates a second-level table, and the walker reads the leaf entry indexed by the next ten bits. If the leaf is valid and its rights allow the access, the walker returns the physical page number together with the untouched 12-bit page offset. If the leaf is valid but the rights do not allow the access, it reports an access violation. If the entry is invalid at either level, it reports a page fault.

Software switches between processes by reloading the table base input. The walker samples that input when it accepts a request, so a change takes effect on the next walk. It talks to memory through a one-deep read port. A request is held until memory accepts it, and a response may arrive any number of cycles later. It takes one walk at a time and ends each walk with a one-cycle completion pulse.

Top module: `pgwalk_top`

## Requirements
- R1: The first memory read of a walk is at address tableBase + 4 × vaddr[31:22], taken modulo 2^30. tableBase is the value sampled in the cycle the request is accepted.
- R2: Entry layout: bit 0 is valid, bit 1 allows read, bit 2 allows write, bit 3 allows execute, and bits 31:14 hold an 18-bit page number. All other bits are ignored. The second read is at {first-level page number, 12'b0} + 4 × vaddr[21:12].
- R3: An invalid first-level entry ends the walk with resultKind = 1 (fault), resultPpn = 0 and resultRights = 0. No second read is made.
- R4: An invalid leaf entry ends the walk with resultKind = 1, resultPpn = 0 and resultRights = 0.
- R5: reqAccess encodes 0 = read, 1 = write, 2 = execute. Code 3 is never permitted. A valid leaf whose matching right bit is clear gives resultKind = 2 (violation) and resultPpn = 0. resultRights still shows the leaf's {X,W,R}.
- R6: A valid, permitted leaf gives resultKind = 0, resultPpn = the leaf page number, resultRights = {X,W,R} of the leaf, and resultPaddr = {resultPpn, vaddr[11:0]}.
- R7: While memReqValid is high and memReqReady is low, memReqValid stays high and memReqAddr stays unchanged in the next cycle. No new memory request is raised while a read is outstanding. Every request address is word aligned.
- R8: After reset, reqReady is 1, and memReqValid and done are 0. A request is accepted only when reqReady is 1. reqReady stays 0 from acceptance until the cycle after done. done is high for exactly one cycle per walk, and the results are valid while done is high.
- R9: Reloading tableBase between walks makes the next walk read the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tableBase | input | 30 | Physical byte address of the first-level table |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker is idle and takes a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 30 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle pulse: walk finished |
| resultKind | output | 2 | 0 ok, 1 page fault, 2 access violation |
| resultPpn | output | 18 | Translated physical page number |
| resultPaddr | output | 30 | Translated physical address |
| resultRights | output | 3 | Leaf rights {X,W,R} |

## Verification
On every cycle, the assertions check the memory-side protocol. Requests are held stable until accepted, no request is raised while a read is in flight, and every address is word aligned. They also check the request side: done lasts one cycle, the walker returns to idle right after done, an accepted request leads straight to a memory read, and no illegal result code appears. Whether the addresses, the number of reads, the fault and violation decisions and the assembled physical address are correct can only be shown by the bench. The bench sweeps first- and second-level indices, including the highest index values, and all four access codes. It runs against a computed table with two different base values, and its memory varies both the acceptance stalls and the response latency.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PTE_W  = 32;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int HI_LSB = OFF_W + IDX_W;
  localparam int PPN_LSB = PTE_W - PPN_W;
  localparam int RIGHTS_W = 3;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_FAULT = 2'd1,
    RES_VIOL  = 2'd2
  } resKind_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } access_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walkState_e;

  typedef struct packed {
    logic takeReq;
    logic takeDir;
    logic takeLeaf;
  } walkStrobe_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        done,
  output walkStrobe_t strobe
);
  walkState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    done        = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.takeReq = 1'b1;
          stateD = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (memRspValid) begin
          strobe.takeDir = 1'b1;
          stateD = entryValid ? ST_L2_REQ : ST_DONE;
        end
      end
      ST_L2_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (memRspValid) begin
          strobe.takeLeaf = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [PA_W-1:0]     tableBase,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [1:0]          reqAccess,
  input  logic [PTE_W-1:0]    memRspData,
  output logic                entryValid,
  output logic [PA_W-1:0]     memReqAddr,
  output logic [1:0]          resultKind,
  output logic [PPN_W-1:0]    resultPpn,
  output logic [PA_W-1:0]     resultPaddr,
  output logic [RIGHTS_W-1:0] resultRights
);
  localparam int PAD_W = PA_W - IDX_W - 2;

  logic [PA_W-1:0]     addrQ;
  logic [IDX_W-1:0]    loIdxQ;
  logic [OFF_W-1:0]    offQ;
  logic [1:0]          accQ;
  resKind_e            kindQ;
  logic [PPN_W-1:0]    ppnQ;
  logic [RIGHTS_W-1:0] rightsQ;

  logic [RIGHTS_W-1:0] entRights;
  logic [PPN_W-1:0]    entPpn;
  logic                permit;

  assign entryValid = memRspData[0];
  assign entRights  = memRspData[RIGHTS_W:1];
  assign entPpn     = memRspData[PTE_W-1:PPN_LSB];

  always_comb begin
    unique case (accQ)
      ACC_READ:  permit = entRights[0];
      ACC_WRITE: permit = entRights[1];
      ACC_EXEC:  permit = entRights[2];
      default:   permit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      loIdxQ  <= '0;
      offQ    <= '0;
      accQ    <= '0;
      kindQ   <= RES_OK;
      ppnQ    <= '0;
      rightsQ <= '0;
    end else begin
      if (strobe.takeReq) begin
        addrQ  <= tableBase + {{PAD_W{1'b0}}, reqVaddr[VA_W-1:HI_LSB], 2'b00};
        loIdxQ <= reqVaddr[HI_LSB-1:OFF_W];
        offQ   <= reqVaddr[OFF_W-1:0];
        accQ   <= reqAccess;
      end
      if (strobe.takeDir) begin
        if (!entryValid) begin
          kindQ   <= RES_FAULT;
          ppnQ    <= '0;
          rightsQ <= '0;
        end else begin
          addrQ <= {entPpn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, loIdxQ, 2'b00};
        end
      end
      if (strobe.takeLeaf) begin
        if (!entryValid) begin
          kindQ   <= RES_FAULT;
          ppnQ    <= '0;
          rightsQ <= '0;
        end else if (!permit) begin
          kindQ   <= RES_VIOL;
          ppnQ    <= '0;
          rightsQ <= entRights;
        end else begin
          kindQ   <= RES_OK;
          ppnQ    <= entPpn;
          rightsQ <= entRights;
        end
      end
    end
  end

  assign memReqAddr   = addrQ;
  assign resultKind   = kindQ;
  assign resultPpn    = ppnQ;
  assign resultPaddr  = {ppnQ, offQ};
  assign resultRights = rightsQ;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PA_W-1:0]     tableBase,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [1:0]          reqAccess,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [PA_W-1:0]     memReqAddr,
  input  logic                memRspValid,
  input  logic [PTE_W-1:0]    memRspData,
  output logic                done,
  output logic [1:0]          resultKind,
  output logic [PPN_W-1:0]    resultPpn,
  output logic [PA_W-1:0]     resultPaddr,
  output logic [RIGHTS_W-1:0] resultRights
);
  walkStrobe_t strobe;
  logic        entryValid;

  pgwalk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .entryValid(entryValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .done(done), .strobe(strobe)
  );

  pgwalk_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tableBase(tableBase),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .memRspData(memRspData),
    .entryValid(entryValid), .memReqAddr(memReqAddr), .resultKind(resultKind),
    .resultPpn(resultPpn), .resultPaddr(resultPaddr), .resultRights(resultRights)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memRspValid,
  input logic            done,
  input logic [1:0]      resultKind
);
  logic pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else if (memReqValid && memReqReady) pendQ <= 1'b1;
    else if (memRspValid) pendQ <= 1'b0;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> !memReqValid);
  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);
  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady && memReqValid);
  // R5
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resultKind != 2'd3);
endmodule

bind pgwalk_top pgwalk_chk i_pgwalk_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .done(done), .resultKind(resultKind)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [29:0] tableBase = 30'h1000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [29:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done;
  logic [1:0]  resultKind;
  logic [17:0] resultPpn;
  logic [29:0] resultPaddr;
  logic [2:0]  resultRights;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // memory model state
  int          reads = 0;
  logic [29:0] log0 = '0, log1 = '0;
  bit          busy = 1'b0;
  int          lat = 0;
  int          pace = 0;
  logic [29:0] pendAddr = '0;

  always #2 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .reqValid(reqValid),
    .reqReady(reqReady), .reqVaddr(reqVaddr), .reqAccess(reqAccess),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .resultKind(resultKind), .resultPpn(resultPpn), .resultPaddr(resultPaddr),
    .resultRights(resultRights)
  );

  function automatic logic [31:0] pteAt(input logic [29:0] a);
    logic [31:0] w;
    int idx, key;
    logic [17:0] ppn;
    w = '0;
    if (a >= tableBase && a < tableBase + 30'd4096) begin
      idx = int'((a - tableBase) >> 2);
      ppn = 18'(32'h200 + idx + ((tableBase >> 12) & 15) * 64);
      w = {ppn, 13'd0, ((idx % 4) != 3)};
    end else if (a[29:12] >= 18'h200) begin
      key = int'(a[29:12]) - 32'h200;
      idx = int'(a[11:2]);
      ppn = 18'(((key << 10) | idx) + 1);
      w = {ppn, 10'h2A5, 3'((idx + key) % 8), ((idx % 5) != 4)};
    end
    return w;
  endfunction

  // memory responder: stalls acceptance and varies latency
  initial forever begin
    @(negedge clk);
    memRspValid = 1'b0;
    if (busy) begin
      lat = lat - 1;
      if (lat == 0) begin
        memRspValid = 1'b1;
        memRspData = pteAt(pendAddr);
        busy = 1'b0;
      end
      memReqReady = 1'b0;
    end else begin
      pace = pace + 1;
      memReqReady = !memRspValid && ((pace % 3) != 1);
      if (memReqValid && memReqReady) begin
        busy = 1'b1;
        lat = 1 + (pace % 3);
        pendAddr = memReqAddr;
        if (reads == 0) log0 = memReqAddr; else log1 = memReqAddr;
        reads = reads + 1;
      end
    end
  end

  initial forever begin
    @(posedge clk);
    cycles = cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<150000)", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input string baseTag);
    logic [29:0] a1, a2;
    logic [31:0] e1, e2;
    logic [1:0]  expKind;
    logic [17:0] expPpn;
    logic [2:0]  expRights;
    int          expReads;
    bit          perm;
    int          guard;
    a1 = tableBase + {18'd0, va[31:22], 2'b00};
    e1 = pteAt(a1);
    a2 = {e1[31:14], 12'd0} + {18'd0, va[21:12], 2'b00};
    e2 = pteAt(a2);
    case (acc)
      2'd0: perm = e2[1];
      2'd1: perm = e2[2];
      2'd2: perm = e2[3];
      default: perm = 1'b0;
    endcase
    if (!e1[0]) begin expKind = 2'd1; expPpn = 0; expRights = 0; expReads = 1; end
    else if (!e2[0]) begin expKind = 2'd1; expPpn = 0; expRights = 0; expReads = 2; end
    else if (!perm) begin expKind = 2'd2; expPpn = 0; expRights = e2[3:1]; expReads = 2; end
    else begin expKind = 2'd0; expPpn = e2[31:14]; expRights = e2[3:1]; expReads = 2; end

    guard = 0;
    while (!reqReady && guard < 50) begin @(negedge clk); guard++; end
    reads = 0;
    reqVaddr = va;
    reqAccess = acc;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = ~va;
    tableBase = tableBase;
    chk(reqReady == 1'b0, "R8", "busy after accept", reqReady, 0);
    guard = 0;
    while (!done && guard < 100) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R8", "walk completes", done, 1);
    chk(log0 == a1, "R1", {"first read address ", baseTag}, log0, a1);
    chk(reads == expReads, expReads == 1 ? "R3" : "R2", "read count", reads, expReads);
    if (expReads == 2) chk(log1 == a2, "R2", "second read address", log1, a2);
    chk(resultKind == expKind,
        expKind == 2'd1 ? (expReads == 1 ? "R3" : "R4") : (expKind == 2'd2 ? "R5" : "R6"),
        "result kind", resultKind, expKind);
    chk(resultPpn == expPpn, expKind == 2'd0 ? "R6" : "R5", "page number", resultPpn, expPpn);
    chk(resultRights == expRights, expKind == 2'd0 ? "R6" : "R4", "rights", resultRights, expRights);
    if (expKind == 2'd0)
      chk(resultPaddr == {expPpn, va[11:0]}, "R6", "physical address", resultPaddr, {expPpn, va[11:0]});
    @(negedge clk);
    chk(done == 1'b0 && reqReady == 1'b1, "R8", "done single pulse then idle", {done, reqReady}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R8", "reset reqReady", reqReady, 1);
    chk(memReqValid == 1'b0, "R8", "reset memReqValid", memReqValid, 0);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    // idle request-free cycles raise no memory read
    chk(memReqValid == 1'b0, "R8", "idle no read", memReqValid, 0);

    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 10; j++) begin
        for (int acc = 0; acc < 4; acc++) begin
          logic [9:0] hi, lo;
          hi = (k < 6) ? 10'(k) : 10'(1016 + k);
          lo = (j < 8) ? 10'(j) : 10'(1014 + j);
          walk({hi, lo, 12'((k * 37 + j * 101 + acc) & 12'hfff)}, 2'(acc), "base A");
        end
      end
    end

    // R9: process switch to another table
    tableBase = 30'h3000;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 5; j++)
        for (int acc = 0; acc < 4; acc++)
          walk({10'(k), 10'(j), 12'(k * 3 + j)}, 2'(acc), "R9 base B");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule